// File: doc/BRIEF.md
# Windowed Register File

This block is the integer register file of a processor core whose instructions name operands with a 5-bit field. The 32 logical registers seen by an instruction are not a flat array. Logical registers 0 to 7 are a fixed global set. Logical registers 8 to 31 are taken from the current window, which is one position on a ring of physical windowed registers. A window pointer selects that position.

Each window spans 24 physical registers and starts 16 registers after the window before it. The top eight registers of window k are therefore the same storage as the bottom eight of window k+1, and a caller passes arguments to a callee with no copying. The eight registers in the middle of each window belong to that window alone. Because the windows form a ring, the top of the last window aliases the bottom of window 0.

A save command moves the pointer to the next window and a restore command moves it back. The block counts how many windows are in use and flags overflow or underflow when a command would go past either end. There are two combinational read ports and one write port that commits on the clock edge. A read of the register being written in the same cycle returns the incoming data.

Top module: `win_regfile`

## Requirements
- R1: After reset the window pointer is 0, both flags are low, exactly one window is in use, and every register reads as zero.
- R2: Logical registers 0–7 address the same storage for every value of the window pointer.
- R3: With window pointer p, logical register r in 16–23 is private to window p. A value written there is not visible through any logical register of window p+1, and it is still present after returning to window p.
- R4: With window pointer p, logical register 24+i (i in 0–7) is the same storage as logical register 8+i of window p+1.
- R5: A save command (save high, restore low) that does not overflow sets the window pointer to (p+1) mod NUM_WIN on the clock edge. A restore command that does not underflow sets it to (p−1) mod NUM_WIN.
- R6: A save issued while NUM_WIN windows are in use leaves the pointer unchanged and raises overflow_o for exactly the one cycle after that edge.
- R7: A restore issued while only one window is in use leaves the pointer unchanged and raises underflow_o for exactly the one cycle after that edge.
- R8: Save and restore asserted in the same cycle do nothing: the pointer stays put and neither flag rises.
- R9: A write commits on the clock edge. During the write cycle, a read port whose logical address maps to the same physical register returns the write data.
- R10: The windows form a ring: logical 24–31 of window NUM_WIN−1 are the same storage as logical 8–15 of window 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| save_i | input | 1 | Advance to the next window |
| restore_i | input | 1 | Return to the previous window |
| we_i | input | 1 | Write enable |
| waddr_i | input | 5 | Logical write register |
| wdata_i | input | DATA_W | Write data |
| raddr_a_i | input | 5 | Logical read register, port A |
| raddr_b_i | input | 5 | Logical read register, port B |
| rdata_a_o | output | DATA_W | Read data, port A |
| rdata_b_o | output | DATA_W | Read data, port B |
| cwp_o | output | clog2(NUM_WIN) | Current window pointer |
| overflow_o | output | 1 | One-cycle pulse: save was refused |
| underflow_o | output | 1 | One-cycle pulse: restore was refused |

## Verification
Assertions check on every cycle the pointer rules. The pointer steps by exactly one on an accepted save or restore, it holds on a refused command or on a collision of both commands, the two flags never rise together, the count of windows in use stays in range, and a write lands in the register it names. The address aliasing cannot be seen cycle by cycle from the ports. Only the bench scenarios show it: globals kept across windows, shared registers between neighbouring windows, private registers hidden from the next window, and the ring closing between the last window and window 0. Those scenarios write through one window and read back through another.

// File: rtl/wrf_pkg.sv
package wrf_pkg;
  localparam int unsigned LREG_W     = 5;   // logical specifier width
  localparam int unsigned NUM_GLOBAL = 8;   // always-visible registers
  localparam int unsigned WIN_STRIDE = 16;  // new registers per window
  localparam int unsigned WIN_SPAN   = 24;  // windowed registers seen at once
endpackage

// File: rtl/wrf_addr_map.sv
module wrf_addr_map
  import wrf_pkg::*;
#(
  parameter int unsigned NUM_WIN = 8,
  parameter int unsigned CWP_W   = $clog2(NUM_WIN),
  parameter int unsigned PHYS_W  = $clog2(NUM_GLOBAL + NUM_WIN * WIN_STRIDE)
) (
  input  logic [LREG_W-1:0] lreg_i,
  input  logic [CWP_W-1:0]  cwp_i,
  output logic [PHYS_W-1:0] preg_o
);
  localparam int unsigned WIN_REGS = NUM_WIN * WIN_STRIDE;
  localparam int unsigned IDX_W    = $clog2(WIN_REGS) + 1;
  localparam logic [IDX_W-1:0] WIN_REGS_L = IDX_W'(WIN_REGS);

  logic [IDX_W-1:0] base, offs, sum, wrapped;

  always_comb begin
    base    = IDX_W'(cwp_i) * IDX_W'(WIN_STRIDE);
    offs    = IDX_W'(lreg_i) - IDX_W'(NUM_GLOBAL);
    sum     = base + offs;
    // sum stays below 2*WIN_REGS, so a single subtraction closes the ring
    wrapped = (sum >= WIN_REGS_L) ? sum - WIN_REGS_L : sum;
    if (lreg_i < LREG_W'(NUM_GLOBAL)) preg_o = PHYS_W'(lreg_i);
    else                              preg_o = PHYS_W'(wrapped) + PHYS_W'(NUM_GLOBAL);
  end
endmodule

// File: rtl/wrf_window_ctrl.sv
module wrf_window_ctrl #(
  parameter int unsigned NUM_WIN = 8,
  parameter int unsigned CWP_W   = $clog2(NUM_WIN)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             save_i,
  input  logic             restore_i,
  output logic [CWP_W-1:0] cwp_o,
  output logic             overflow_o,
  output logic             underflow_o
);
  localparam int unsigned OCC_W = $clog2(NUM_WIN + 1);
  localparam logic [CWP_W-1:0] LAST_WIN = CWP_W'(NUM_WIN - 1);

  logic [CWP_W-1:0] cwp_q;
  logic [OCC_W-1:0] occ_q;
  logic             ovf_q, unf_q;
  logic             do_save, do_rest, full, single;

  function automatic logic [CWP_W-1:0] ptr_inc(input logic [CWP_W-1:0] p);
    return (p == LAST_WIN) ? '0 : p + CWP_W'(1);
  endfunction

  function automatic logic [CWP_W-1:0] ptr_dec(input logic [CWP_W-1:0] p);
    return (p == '0) ? LAST_WIN : p - CWP_W'(1);
  endfunction

  assign do_save = save_i & ~restore_i;
  assign do_rest = restore_i & ~save_i;
  assign full    = (occ_q == OCC_W'(NUM_WIN));
  assign single  = (occ_q == OCC_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cwp_q <= '0;
      occ_q <= OCC_W'(1);
      ovf_q <= 1'b0;
      unf_q <= 1'b0;
    end else begin
      ovf_q <= do_save & full;
      unf_q <= do_rest & single;
      if (do_save && !full) begin
        cwp_q <= ptr_inc(cwp_q);
        occ_q <= occ_q + OCC_W'(1);
      end else if (do_rest && !single) begin
        cwp_q <= ptr_dec(cwp_q);
        occ_q <= occ_q - OCC_W'(1);
      end
    end
  end

  assign cwp_o       = cwp_q;
  assign overflow_o  = ovf_q;
  assign underflow_o = unf_q;

  p_save_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (save_i && !restore_i && !full) |=> cwp_q == ptr_inc($past(cwp_q)));
  p_rest_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (restore_i && !save_i && !single) |=> cwp_q == ptr_dec($past(cwp_q)));
  p_no_overflow_move_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_q |-> $stable(cwp_q));
  p_no_underflow_move_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unf_q |-> $stable(cwp_q));
  p_both_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (save_i && restore_i) |=> ($stable(cwp_q) && !ovf_q && !unf_q));
  p_flags_excl_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ovf_q && unf_q));
  p_occ_range_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (occ_q >= OCC_W'(1)) && (occ_q <= OCC_W'(NUM_WIN)));
endmodule

// File: rtl/wrf_storage.sv
module wrf_storage #(
  parameter int unsigned PHYS_N = 136,
  parameter int unsigned PHYS_W = $clog2(PHYS_N),
  parameter int unsigned DATA_W = 32,
  parameter int unsigned NUM_RD = 2
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           we_i,
  input  logic [PHYS_W-1:0]              waddr_i,
  input  logic [DATA_W-1:0]              wdata_i,
  input  logic [NUM_RD-1:0][PHYS_W-1:0]  raddr_i,
  output logic [NUM_RD-1:0][DATA_W-1:0]  rdata_o
);
  logic [DATA_W-1:0] regs_q [PHYS_N];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(PHYS_N); i++) regs_q[i] <= '0;
    end else if (we_i) begin
      regs_q[waddr_i] <= wdata_i;
    end
  end

  for (genvar g = 0; g < int'(NUM_RD); g++) begin : g_rd
    // same-cycle write is forwarded to the reader
    assign rdata_o[g] = (we_i && waddr_i == raddr_i[g]) ? wdata_i : regs_q[raddr_i[g]];
  end

  p_write_commit_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> regs_q[$past(waddr_i)] == $past(wdata_i));
endmodule

// File: rtl/win_regfile.sv
module win_regfile
  import wrf_pkg::*;
#(
  parameter int unsigned NUM_WIN = 8,
  parameter int unsigned DATA_W  = 32
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       save_i,
  input  logic                       restore_i,
  input  logic                       we_i,
  input  logic [4:0]                 waddr_i,
  input  logic [DATA_W-1:0]          wdata_i,
  input  logic [4:0]                 raddr_a_i,
  input  logic [4:0]                 raddr_b_i,
  output logic [DATA_W-1:0]          rdata_a_o,
  output logic [DATA_W-1:0]          rdata_b_o,
  output logic [$clog2(NUM_WIN)-1:0] cwp_o,
  output logic                       overflow_o,
  output logic                       underflow_o
);
  localparam int unsigned CWP_W  = $clog2(NUM_WIN);
  localparam int unsigned PHYS_N = NUM_GLOBAL + NUM_WIN * WIN_STRIDE;
  localparam int unsigned PHYS_W = $clog2(PHYS_N);
  localparam int unsigned NUM_RD = 2;
  localparam int unsigned NUM_MAP = NUM_RD + 1;  // slot 0 is the write port

  logic [CWP_W-1:0]                 cwp;
  logic [NUM_MAP-1:0][LREG_W-1:0]   lregs;
  logic [NUM_MAP-1:0][PHYS_W-1:0]   pregs;
  logic [NUM_RD-1:0][PHYS_W-1:0]    rd_pregs;
  logic [NUM_RD-1:0][DATA_W-1:0]    rd_data;

  assign lregs = {raddr_b_i, raddr_a_i, waddr_i};

  wrf_window_ctrl #(.NUM_WIN(NUM_WIN), .CWP_W(CWP_W)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .save_i     (save_i),
    .restore_i  (restore_i),
    .cwp_o      (cwp),
    .overflow_o (overflow_o),
    .underflow_o(underflow_o)
  );

  for (genvar m = 0; m < int'(NUM_MAP); m++) begin : g_map
    wrf_addr_map #(.NUM_WIN(NUM_WIN), .CWP_W(CWP_W), .PHYS_W(PHYS_W)) u_map (
      .lreg_i(lregs[m]),
      .cwp_i (cwp),
      .preg_o(pregs[m])
    );
  end

  for (genvar r = 0; r < int'(NUM_RD); r++) begin : g_rsel
    assign rd_pregs[r] = pregs[r+1];
  end

  wrf_storage #(.PHYS_N(PHYS_N), .PHYS_W(PHYS_W), .DATA_W(DATA_W), .NUM_RD(NUM_RD)) u_store (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (we_i),
    .waddr_i(pregs[0]),
    .wdata_i(wdata_i),
    .raddr_i(rd_pregs),
    .rdata_o(rd_data)
  );

  assign rdata_a_o = rd_data[0];
  assign rdata_b_o = rd_data[1];
  assign cwp_o     = cwp;

  // globals never depend on the pointer
  p_global_fixed_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (raddr_a_i < 5'd8) |-> pregs[1] == PHYS_W'(raddr_a_i));
endmodule

// File: tb/win_regfile_tb_top.sv
module win_regfile_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        save = 1'b0, restore = 1'b0, we = 1'b0;
  logic [4:0]  wa = '0, ra = '0, rb = '0;
  logic [31:0] wd = '0;
  logic [31:0] rd_a, rd_b;
  logic [2:0]  cwp;
  logic        ovf, unf;
  int          total = 0;
  int          bad = 0;

  always #5 clk = ~clk;

  win_regfile dut_i (
    .clk_i(clk), .rst_ni(rst_n), .save_i(save), .restore_i(restore),
    .we_i(we), .waddr_i(wa), .wdata_i(wd), .raddr_a_i(ra), .raddr_b_i(rb),
    .rdata_a_o(rd_a), .rdata_b_o(rd_b), .cwp_o(cwp),
    .overflow_o(ovf), .underflow_o(unf)
  );

  // {op[1:0] (1 save, 2 restore, 3 both), cwp after, 0, overflow, underflow}
  localparam int NV = 20;
  localparam logic [7:0] VEC [NV] = '{
    {2'd2, 3'd0, 1'b0, 1'b0, 1'b1},
    {2'd1, 3'd1, 1'b0, 1'b0, 1'b0},
    {2'd1, 3'd2, 1'b0, 1'b0, 1'b0},
    {2'd1, 3'd3, 1'b0, 1'b0, 1'b0},
    {2'd1, 3'd4, 1'b0, 1'b0, 1'b0},
    {2'd1, 3'd5, 1'b0, 1'b0, 1'b0},
    {2'd1, 3'd6, 1'b0, 1'b0, 1'b0},
    {2'd1, 3'd7, 1'b0, 1'b0, 1'b0},
    {2'd1, 3'd7, 1'b0, 1'b1, 1'b0},
    {2'd3, 3'd7, 1'b0, 1'b0, 1'b0},
    {2'd2, 3'd6, 1'b0, 1'b0, 1'b0},
    {2'd2, 3'd5, 1'b0, 1'b0, 1'b0},
    {2'd2, 3'd4, 1'b0, 1'b0, 1'b0},
    {2'd1, 3'd5, 1'b0, 1'b0, 1'b0},
    {2'd2, 3'd4, 1'b0, 1'b0, 1'b0},
    {2'd2, 3'd3, 1'b0, 1'b0, 1'b0},
    {2'd2, 3'd2, 1'b0, 1'b0, 1'b0},
    {2'd2, 3'd1, 1'b0, 1'b0, 1'b0},
    {2'd2, 3'd0, 1'b0, 1'b0, 1'b0},
    {2'd2, 3'd0, 1'b0, 1'b0, 1'b1}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // inputs are driven at the falling edge; results are sampled at the next one
  task automatic tick(input logic sv, input logic rs, input logic w,
                      input logic [4:0] a, input logic [31:0] d);
    save = sv; restore = rs; we = w; wa = a; wd = d;
    @(posedge clk);
    @(negedge clk);
    save = 1'b0; restore = 1'b0; we = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [4:0] a, input logic [31:0] exp);
    ra = a;
    #1;
    chk(tag, rd_a, exp);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset state
    chk("R1 cwp", 32'(cwp), 32'd0);
    chk("R1 ovf", 32'(ovf), 32'd0);
    chk("R1 unf", 32'(unf), 32'd0);
    rd_chk("R1 r5 zero", 5'd5, 32'd0);
    rd_chk("R1 r20 zero", 5'd20, 32'd0);

    // table walk over pointer commands: R5 R6 R7 R8
    for (int i = 0; i < NV; i++) begin
      logic [1:0] op;
      op = VEC[i][7:6];
      tick(op[0], op[1], 1'b0, 5'd0, 32'd0);
      chk((op == 2'd3) ? "R8 cwp" : "R5 cwp", 32'(cwp), 32'(VEC[i][5:3]));
      chk((op == 2'd3) ? "R8 ovf" : "R6 ovf", 32'(ovf), 32'(VEC[i][1]));
      chk((op == 2'd3) ? "R8 unf" : "R7 unf", 32'(unf), 32'(VEC[i][0]));
    end
    tick(1'b0, 1'b0, 1'b0, 5'd0, 32'd0);
    chk("R6 ovf one cycle", 32'(ovf), 32'd0);
    chk("R7 unf one cycle", 32'(unf), 32'd0);

    // directed: reset clears contents
    do_reset();
    chk("R1 cwp after rerun", 32'(cwp), 32'd0);

    // R9 forwarding in the write cycle, then commit
    we = 1'b1; wa = 5'd5; wd = 32'h5555_0005; ra = 5'd5;
    #1;
    chk("R9 forward", rd_a, 32'h5555_0005);
    @(posedge clk);
    @(negedge clk);
    we = 1'b0;
    rd_chk("R9 commit", 5'd5, 32'h5555_0005);

    // R2 global survives a save
    tick(1'b0, 1'b0, 1'b1, 5'd3, 32'hA0A0_0003);
    tick(1'b1, 1'b0, 1'b0, 5'd0, 32'd0);
    chk("R5 cwp 1", 32'(cwp), 32'd1);
    rb = 5'd3;
    #1;
    chk("R2 global r3", rd_b, 32'hA0A0_0003);

    // R4 overlap and R3 private registers
    tick(1'b0, 1'b0, 1'b1, 5'd26, 32'hB0B0_001A);
    tick(1'b0, 1'b0, 1'b1, 5'd18, 32'hD0D0_0012);
    tick(1'b1, 1'b0, 1'b0, 5'd0, 32'd0);
    chk("R5 cwp 2", 32'(cwp), 32'd2);
    rd_chk("R4 out to in", 5'd10, 32'hB0B0_001A);
    rd_chk("R3 private hidden", 5'd18, 32'd0);
    tick(1'b0, 1'b0, 1'b1, 5'd12, 32'hC0C0_000C);
    tick(1'b0, 1'b1, 1'b0, 5'd0, 32'd0);
    chk("R5 cwp back 1", 32'(cwp), 32'd1);
    rd_chk("R4 in to out", 5'd28, 32'hC0C0_000C);
    rd_chk("R3 private kept", 5'd18, 32'hD0D0_0012);

    // R10 ring closes between last window and window 0
    do_reset();
    tick(1'b0, 1'b0, 1'b1, 5'd9, 32'hE0E0_0009);
    for (int k = 0; k < 7; k++) tick(1'b1, 1'b0, 1'b0, 5'd0, 32'd0);
    chk("R10 cwp 7", 32'(cwp), 32'd7);
    rd_chk("R10 ring alias", 5'd25, 32'hE0E0_0009);
    rd_chk("R3 other private zero", 5'd17, 32'd0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule